// File: doc/BRIEF.md
# Calibrated RTC Seconds Prescaler

This block turns a nominal 32.768 kHz crystal clock into a one-clock-wide pulse every second, a pulse every half second, and a one-clock marker at the end of each minute. It also corrects a crystal that runs fast or slow. Once per minute the length of one second is trimmed by a signed calibration value times four input clocks. The nominal divider ratio is left alone, and the average seconds rate comes out right over a minute.

The calibration value is an 8-bit two's-complement number. Software loads it through a write strobe. A positive value suits a slow crystal: the trimmed second is shorter, so the minute ends sooner. A negative value suits a fast crystal: the trimmed second is longer. A write is taken only while the divider is disabled, or in the single input cycle in which the seconds pulse is high. This keeps a new value from landing in the middle of a second that is already being counted. Measuring the crystal error and any calendar counting are left to other blocks.

Top module: `rtc_trim_prescaler`

## Requirements
- R1: With the block enabled, every second except the first of each minute lasts exactly TICKS_PER_SEC input clocks (32,768 by default), measured from one seconds pulse to the next.
- R2: The first second of each minute lasts TICKS_PER_SEC - 4*C input clocks, where C is the stored calibration value read as 8-bit two's complement (bit 7 is the sign). A positive C shortens that second and a negative C lengthens it.
- R3: With C = 0, every second of the minute lasts exactly TICKS_PER_SEC input clocks.
- R4: A write is accepted when `cal_wr` is high at a rising clock edge and either `run_en` is low or `tick_1hz` is high in that cycle. A write at any other time leaves the stored value unchanged. An accepted write applies from the second that starts in that cycle.
- R5: `tick_1hz` is high for exactly one input cycle per second. That cycle follows the clock edge at which the divider count reached the last count of the second.
- R6: `tick_2hz` is high for one cycle L/2 clocks after a second starts, where L is the length of that second (the trimmed length in the first second). It is also high together with every `tick_1hz`.
- R7: `tick_min` is high for one cycle, in the same cycle as the SECS_PER_MIN-th seconds pulse of a minute. The seconds count then wraps to zero.
- R8: While `run_en` is low, the divider and the seconds count are held at zero and all three pulse outputs are low. After `run_en` rises, the first second counted is the trimmed first second of a minute and ends L clocks after the first enabled edge.
- R9: After reset, all outputs are low and the stored calibration value is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_xtal | input | 1 | Crystal-domain input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Divider enable; low holds all counts at zero |
| cal_wr | input | 1 | Calibration write strobe |
| cal_val | input | CAL_W | Signed calibration value, in units of 4 clocks |
| tick_1hz | output | 1 | One-cycle seconds pulse |
| tick_2hz | output | 1 | One-cycle half-second pulse |
| tick_min | output | 1 | One-cycle minute marker |

## Verification
The bench runs a shortened second and minute. It goes after the two ends of the calibration range, +127 and -128. A design that treated the value as unsigned, or got the sign backwards, would produce a first second that is far too short or too long. Writes made outside the seconds-pulse cycle are aimed at catching a design that accepts them, which would move the next minute's trimmed second. Disabling in the middle of a second and then enabling again checks that counting restarts with the trimmed second. The half-second pulse is checked against half of the trimmed length, so a design that kept the midpoint at half the nominal length would be caught.

// File: rtl/rtc_trim_pkg.sv
package rtc_trim_pkg;
    // input clocks represented by one unit of the calibration value
    localparam int CAL_STEP = 4;

    // length of a second given the seconds-in-minute position and the trim
    function automatic int sec_length(input int ticks, input bit first, input int cal);
        return first ? (ticks - CAL_STEP * cal) : ticks;
    endfunction
endpackage

// File: rtl/rtc_trim_cal_reg.sv
module rtc_trim_cal_reg #(
    parameter int CAL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             sec_pulse,
    input  logic             cal_wr,
    input  logic [CAL_W-1:0] cal_val,
    output logic [CAL_W-1:0] cal_q
);
    logic [CAL_W-1:0] cal_d;
    logic             take;

    always_comb begin
        take  = cal_wr && (!run_en || sec_pulse);
        cal_d = take ? cal_val : cal_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cal_q <= '0;
        else        cal_q <= cal_d;
    end

    // R4: a write outside the allowed window leaves the value alone
    assert_cal_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cal_wr || (run_en && !sec_pulse)) |=> $stable(cal_q));
    // R4: an allowed write lands in the register
    assert_cal_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_wr && (!run_en || sec_pulse)) |=> (cal_q == $past(cal_val)));
endmodule

// File: rtl/rtc_trim_len.sv
module rtc_trim_len
    import rtc_trim_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768,
    parameter int CAL_W         = 8,
    parameter int CNT_W         = 16
) (
    input  logic             first_sec,
    input  logic [CAL_W-1:0] cal,
    output logic [CNT_W-1:0] last_cnt,
    output logic [CNT_W-1:0] mid_cnt
);
    int cal_i;
    int len_i;

    always_comb begin
        cal_i    = int'($signed(cal));
        len_i    = sec_length(TICKS_PER_SEC, first_sec, cal_i);
        last_cnt = CNT_W'(len_i - 1);
        mid_cnt  = CNT_W'((len_i / 2) - 1);
    end

    // R6: midpoint lies strictly inside the second
    always_comb begin
        assert_mid_inside_R6: assert (mid_cnt < last_cnt);
    end
endmodule

// File: rtl/rtc_trim_div.sv
module rtc_trim_div #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic [CNT_W-1:0] last_cnt,
    input  logic [CNT_W-1:0] mid_cnt,
    output logic             wrap,
    output logic             tick_1hz,
    output logic             tick_2hz
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             t1;
        logic             t2;
    } div_st_t;

    div_st_t st_d, st_q;

    always_comb begin
        st_d = '0;
        wrap = run_en && (st_q.cnt == last_cnt);
        if (run_en) begin
            st_d.cnt = wrap ? '0 : st_q.cnt + 1'b1;
            st_d.t1  = wrap;
            st_d.t2  = wrap || (st_q.cnt == mid_cnt);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_1hz = st_q.t1;
    assign tick_2hz = st_q.t2;

    // R2: the count never runs past the end of the current second
    assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        run_en |-> (st_q.cnt <= last_cnt));
    // R5: the seconds pulse coincides with a fresh count
    assert_pulse_at_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.t1 |-> (st_q.cnt == '0));
    // R5: the seconds pulse is one cycle wide
    assert_pulse_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.t1 |=> !st_q.t1);
    // R6: every seconds pulse is also a half-second pulse
    assert_half_with_sec_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.t1 |-> st_q.t2);
    // R8: disabled means zero count next cycle
    assert_hold_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (st_q.cnt == '0 && !st_q.t1 && !st_q.t2));
endmodule

// File: rtl/rtc_trim_secs.sv
module rtc_trim_secs #(
    parameter int SECS_PER_MIN = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    input  logic wrap,
    output logic first_sec,
    output logic tick_min
);
    localparam int SEC_W = $clog2(SECS_PER_MIN);
    localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(SECS_PER_MIN - 1);

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic             mn;
    } sec_st_t;

    sec_st_t st_d, st_q;

    always_comb begin
        st_d = '0;
        if (run_en) begin
            st_d.sec = st_q.sec;
            if (wrap) st_d.sec = (st_q.sec == SEC_LAST) ? '0 : st_q.sec + 1'b1;
            st_d.mn  = wrap && (st_q.sec == SEC_LAST);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign first_sec = (st_q.sec == '0);
    assign tick_min  = st_q.mn;

    // R7: seconds count stays inside the minute
    assert_sec_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.sec <= SEC_LAST);
    // R7: minute marker coincides with the wrap to zero
    assert_min_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.mn |-> (st_q.sec == '0));
endmodule

// File: rtl/rtc_trim_prescaler.sv
module rtc_trim_prescaler
    import rtc_trim_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768,
    parameter int SECS_PER_MIN  = 60,
    parameter int CAL_W         = 8
) (
    input  logic             clk_xtal,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             cal_wr,
    input  logic [CAL_W-1:0] cal_val,
    output logic             tick_1hz,
    output logic             tick_2hz,
    output logic             tick_min
);
    localparam int MAX_LEN = TICKS_PER_SEC + CAL_STEP * (1 << (CAL_W - 1));
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    logic [CAL_W-1:0] cal_q;
    logic [CNT_W-1:0] last_cnt;
    logic [CNT_W-1:0] mid_cnt;
    logic             first_sec;
    logic             wrap;

    rtc_trim_cal_reg #(.CAL_W(CAL_W)) u_cal (
        .clk       (clk_xtal),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .sec_pulse (tick_1hz),
        .cal_wr    (cal_wr),
        .cal_val   (cal_val),
        .cal_q     (cal_q)
    );

    rtc_trim_len #(
        .TICKS_PER_SEC (TICKS_PER_SEC),
        .CAL_W         (CAL_W),
        .CNT_W         (CNT_W)
    ) u_len (
        .first_sec (first_sec),
        .cal       (cal_q),
        .last_cnt  (last_cnt),
        .mid_cnt   (mid_cnt)
    );

    rtc_trim_div #(.CNT_W(CNT_W)) u_div (
        .clk      (clk_xtal),
        .rst_n    (rst_n),
        .run_en   (run_en),
        .last_cnt (last_cnt),
        .mid_cnt  (mid_cnt),
        .wrap     (wrap),
        .tick_1hz (tick_1hz),
        .tick_2hz (tick_2hz)
    );

    rtc_trim_secs #(.SECS_PER_MIN(SECS_PER_MIN)) u_secs (
        .clk       (clk_xtal),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .wrap      (wrap),
        .first_sec (first_sec),
        .tick_min  (tick_min)
    );

    // R7: minute marker only with a seconds pulse
    assert_min_with_sec_R7: assert property (@(posedge clk_xtal) disable iff (!rst_n)
        tick_min |-> tick_1hz);
    // R8: no pulse follows a disabled edge
    assert_quiet_off_R8: assert property (@(posedge clk_xtal) disable iff (!rst_n)
        !run_en |=> (!tick_1hz && !tick_min));
endmodule

// File: tb/sim_rtc_trim_prescaler.sv
module sim_rtc_trim_prescaler;
    localparam int HZ  = 1024;
    localparam int SPM = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_en = 1'b0;
    logic       cal_wr = 1'b0;
    logic [7:0] cal_val = '0;
    logic       tick_1hz, tick_2hz, tick_min;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit done    = 0;

    int mdl_cal = 0;   // bench model of the stored value
    int cnt     = 0;   // enabled edges since last seconds pulse
    int sidx    = 0;   // second position in minute
    bit mid_seen = 0;
    bit over_rep = 0;

    always #10 clk = ~clk;

    rtc_trim_prescaler #(.TICKS_PER_SEC(HZ), .SECS_PER_MIN(SPM), .CAL_W(8)) u0 (
        .clk_xtal (clk), .rst_n (rst_n), .run_en (run_en),
        .cal_wr (cal_wr), .cal_val (cal_val),
        .tick_1hz (tick_1hz), .tick_2hz (tick_2hz), .tick_min (tick_min)
    );

    function automatic int exp_len(input int pos, input int c);
        return (pos == 0) ? (HZ - 4 * c) : HZ;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // reference monitor: inputs read at the edge, outputs 5 ns after it
    always @(posedge clk) begin
        bit en_s, wr_s, p_old;
        int v_s;
        int L;
        en_s  = run_en;
        wr_s  = cal_wr;
        v_s   = int'($signed(cal_val));
        p_old = tick_1hz;
        if (rst_n) begin
            if (wr_s && (!en_s || p_old)) mdl_cal = v_s;
            if (en_s) cnt++;
            else begin cnt = 0; sidx = 0; mid_seen = 0; over_rep = 0; end
        end
        #5;
        if (rst_n && en_s) begin
            L = exp_len(sidx, mdl_cal);
            if (tick_1hz) begin
                check(cnt == L, (sidx == 0) ? "R2 trimmed second length" : "R1 plain second length", cnt, L);
                check(tick_2hz == 1'b1, "R6 half pulse at end of second", int'(tick_2hz), 1);
                check(mid_seen, "R6 midpoint pulse seen", int'(mid_seen), 1);
                check(tick_min == (sidx == SPM - 1), "R7 minute marker", int'(tick_min), int'(sidx == SPM - 1));
                cnt = 0; mid_seen = 0; over_rep = 0;
                sidx = (sidx == SPM - 1) ? 0 : sidx + 1;
            end else begin
                if (tick_2hz) begin
                    check(cnt == L / 2, "R6 midpoint position", cnt, L / 2);
                    mid_seen = 1;
                end
                if (tick_min) check(0, "R7 marker without seconds pulse", 1, 0);
                if (cnt > L && !over_rep) begin
                    check(0, "R5 seconds pulse missing", cnt, L);
                    over_rep = 1;
                end
            end
        end else if (rst_n) begin
            check(!tick_1hz && !tick_2hz && !tick_min, "R8 outputs low while disabled",
                  int'({tick_1hz, tick_2hz, tick_min}), 0);
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !done) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic wait_min();
        do @(negedge clk); while (!tick_min);
    endtask

    // write in the current negedge-aligned cycle, release next cycle
    task automatic put(input int v);
        cal_wr  = 1'b1;
        cal_val = 8'(v);
        @(negedge clk);
        cal_wr  = 1'b0;
    endtask

    // from a minute marker cycle, count to the next seconds pulse
    task automatic measure_first(input int expv, input string req);
        int n = 0;
        do begin @(negedge clk); n++; end while (!tick_1hz);
        check(n == expv, req, n, expv);
    endtask

    task automatic stray_writes(input int k);
        for (int i = 0; i < k; i++) begin
            repeat ($urandom_range(3, 200)) @(negedge clk);
            while (tick_1hz) @(negedge clk);
            put(int'($urandom_range(0, 255)) - 128);
        end
    endtask

    initial begin
        void'($urandom(32'd20250117));
        repeat (3) @(negedge clk);
        check(!tick_1hz && !tick_2hz && !tick_min, "R9 outputs low in reset", int'({tick_1hz, tick_2hz, tick_min}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!tick_1hz && !tick_2hz && !tick_min, "R9 outputs low after reset", int'({tick_1hz, tick_2hz, tick_min}), 0);

        // R9 / R3: stored value resets to zero, all seconds nominal
        run_en = 1'b1;
        wait_min();
        measure_first(HZ, "R3 first second with zero trim");
        wait_min();

        // R2: extremes of the signed range, written in the marker cycle
        wait_min();
        put(127);
        wait_min();
        measure_first(HZ - 4 * 127, "R2 trim +127 first second");
        wait_min();
        put(-128);
        wait_min();
        measure_first(HZ + 4 * 128, "R2 trim -128 first second");

        // R4: writes away from the pulse cycle are ignored
        wait_min();
        put(10);
        stray_writes(6);
        wait_min();
        measure_first(HZ - 40, "R4 stray writes ignored");

        // R8 / R4: disable mid-second, write while off, re-enable
        repeat (300) @(negedge clk);
        run_en = 1'b0;
        repeat (5) @(negedge clk);
        put(-7);
        repeat (3) @(negedge clk);
        run_en = 1'b1;
        wait_min();

        // random mix of accepted, ignored and off-time writes
        for (int it = 0; it < 10; it++) begin
            int mode = int'($urandom_range(0, 2));
            int v    = int'($urandom_range(0, 255)) - 128;
            if (mode == 0) begin
                wait_min(); put(v);
            end else if (mode == 1) begin
                do @(negedge clk); while (!tick_1hz);
                put(v);
                stray_writes(2);
            end else begin
                repeat ($urandom_range(10, 900)) @(negedge clk);
                run_en = 1'b0;
                repeat (2) @(negedge clk);
                put(v);
                run_en = 1'b1;
            end
            wait_min();
        end

        wait_min();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule